// File: doc/BRIEF.md
# Byte-Wide Memory Configuration Loader

This block reads a configuration image out of an external byte-wide read-only memory and sends it out again as a serial bit stream. Downstream devices chained behind the loader can sample that stream. The block drives an 18-bit address, takes in each data byte on the rising edge of a byte read clock, and shifts the byte out least significant bit first. Each bit is launched on the falling edge of a bit clock. The bit clock and the byte read clock both come from one system clock. The bit clock period is a parameter, and the byte read clock runs at exactly one eighth of the bit clock.

A load runs only while the three-bit mode input holds 3'b100. A start pulse, or the release of the active-low program input, begins a load at address zero. The first byte period only prefetches byte 0 and keeps the serial output low. In every later byte period the byte captured in the previous period goes out while the next one is fetched. The last period fetches nothing. Once the last bit of the final byte has gone out, the done flag rises and the loader rests quietly until a new start. Any other mode code, or the program input held low, aborts the load at once and returns the address to zero. A parameter can mirror the bits of each byte before they are serialized, for memories whose data lines are wired in reverse.

Top module: `cfg_byte_loader`

## Requirements
- R1: The 18-bit address is 0 when a load begins, rises by exactly one on each rising edge of the byte read clock, and rests at BYTE_COUNT once the load is done.
- R2: In each byte period of eight bit periods, the byte read clock is low for bit periods 0 to 3 and high for 4 to 7, changing together with the falling bit-clock edge. It stays low in the final period, so exactly BYTE_COUNT bytes are fetched.
- R3: The bit clock has a period of 2*CLK_DIV system clocks. It rises first CLK_DIV system clocks after the cycle in which a load starts, so bit period p begins 2*CLK_DIV*p cycles after that start.
- R4: Serial data changes only with a falling bit-clock edge. It is low during the prefetch period. In byte period k (k >= 1), bit period b carries bit b of byte k-1, least significant bit first.
- R5: With MIRROR set, bit period b of byte period k carries bit 7-b of byte k-1 instead.
- R6: The done flag rises on the falling bit-clock edge that ends byte period BYTE_COUNT, where busy drops. It stays high, with bit clock, byte read clock and serial data low, until the next start or abort.
- R7: While the mode input is not 3'b100, start is ignored. Busy, done, both clocks and serial data are low and the address is 0 from the next cycle on, and a running load is aborted.
- R8: While program_n is low, the load is aborted with the address at 0 and done low. When program_n returns high with the mode at 3'b100, a new load starts from address 0.
- R9: After reset the loader is idle, with address 0, done low and all clocks and data low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| program_n | input | 1 | Active-low abort; its release restarts a load |
| mode | input | 3 | Load mode select; 3'b100 enables the loader |
| start | input | 1 | One-cycle pulse that begins a load |
| rom_data | input | 8 | Data byte from the external memory |
| rom_addr | output | 18 | Byte address to the external memory |
| bit_clk | output | 1 | Serial bit clock for chained devices |
| byte_clk | output | 1 | Byte read clock, one eighth of the bit clock |
| ser_out | output | 1 | Serial configuration data |
| busy | output | 1 | High while a load is in progress |
| done | output | 1 | High once a load has completed |

## Verification
The assertions assume that rom_data is stable at the system-clock edge where the byte read clock rises, since that edge captures it. They also assume that start and program_n change only between clock edges, so that a restart is seen as a single event. The bench meets both conditions. It computes the memory data combinationally from the address, which changes only one edge after each capture, and it drives every input on the falling system-clock edge. Stimulus covers complete loads, a program abort and release in mid-load, a start attempted under a wrong mode code, and a mode change during a running load.

// File: rtl/cfg_ldr_pkg.sv
package cfg_ldr_pkg;

    typedef enum logic [1:0] {
        LDR_IDLE = 2'd0,
        LDR_RUN  = 2'd1,
        LDR_DONE = 2'd2
    } ldr_state_e;

    localparam logic [2:0] MODE_BYTE_LOAD = 3'b100;
    localparam int unsigned BITS_PER_BYTE = 8;

endpackage

// File: rtl/cfg_ldr_bitclk.sv
module cfg_ldr_bitclk #(
    parameter int unsigned CLK_DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic bit_clk,
    output logic fall_evt
);
    localparam int unsigned DIV_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;

    typedef struct packed {
        logic [DIV_W-1:0] div;
        logic             bclk;
    } bclk_regs_t;

    bclk_regs_t r_q, r_d;
    logic       tick;

    assign tick     = run && (r_q.div == DIV_W'(CLK_DIV - 1));
    assign fall_evt = tick && r_q.bclk;
    assign bit_clk  = r_q.bclk;

    always_comb begin
        r_d = r_q;
        if (!run) begin
            r_d.div  = '0;
            r_d.bclk = 1'b0;
        end else if (tick) begin
            r_d.div  = '0;
            r_d.bclk = ~r_q.bclk;
        end else begin
            r_d.div = r_q.div + DIV_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    // R3: the bit clock is parked low whenever the divider is stopped
    assert_bitclk_parked_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !bit_clk);

endmodule

// File: rtl/cfg_ldr_shifter.sv
module cfg_ldr_shifter #(
    parameter bit MIRROR = 1'b0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear,
    input  logic       load,
    input  logic       shift,
    input  logic [7:0] din,
    output logic       ser
);
    typedef struct packed {
        logic [7:0] sh;
        logic       ser;
    } shf_regs_t;

    shf_regs_t  r_q, r_d;
    logic [7:0] ordered;

    generate
        if (MIRROR) begin : g_mirror
            for (genvar i = 0; i < 8; i++) begin : g_bit
                assign ordered[i] = din[7-i];
            end
        end else begin : g_direct
            assign ordered = din;
        end
    endgenerate

    always_comb begin
        r_d = r_q;
        if (clear) begin
            r_d = '0;
        end else if (load) begin
            r_d.ser = ordered[0];
            r_d.sh  = {1'b0, ordered[7:1]};
        end else if (shift) begin
            r_d.ser = r_q.sh[0];
            r_d.sh  = {1'b0, r_q.sh[7:1]};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign ser = r_q.ser;

    // R4: a cleared shifter drives a low serial bit
    assert_clear_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> !ser);

endmodule

// File: rtl/cfg_byte_loader.sv
module cfg_byte_loader
    import cfg_ldr_pkg::*;
#(
    parameter int unsigned ADDR_W     = 18,
    parameter int unsigned CLK_DIV    = 2,
    parameter int unsigned BYTE_COUNT = 16,
    parameter bit          MIRROR     = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              program_n,
    input  logic [2:0]        mode,
    input  logic              start,
    input  logic [7:0]        rom_data,
    output logic [ADDR_W-1:0] rom_addr,
    output logic              bit_clk,
    output logic              byte_clk,
    output logic              ser_out,
    output logic              busy,
    output logic              done
);
    localparam int unsigned SLOT_W   = $clog2(BYTE_COUNT + 1);
    localparam logic [2:0]  LAST_BIT = 3'(BITS_PER_BYTE - 1);
    localparam logic [2:0]  HIGH_BIT = 3'(BITS_PER_BYTE / 2);

    typedef struct packed {
        ldr_state_e        state;
        logic [ADDR_W-1:0] addr;
        logic [2:0]        bidx;
        logic [SLOT_W-1:0] slot;
        logic              bclk_byte;
        logic [7:0]        hold;
        logic              done;
        logic              prog;
    } ldr_regs_t;

    ldr_regs_t r_q, r_d;
    logic      start_evt, abort, fall_evt, run_div;
    logic      sh_clear, sh_load, sh_shift;

    assign abort     = !program_n || (mode != MODE_BYTE_LOAD);
    assign start_evt = (start || (program_n && !r_q.prog)) && (mode == MODE_BYTE_LOAD);
    assign run_div   = (r_q.state == LDR_RUN) && !abort && !start_evt;

    cfg_ldr_bitclk #(.CLK_DIV(CLK_DIV)) u_bitclk (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run_div),
        .bit_clk  (bit_clk),
        .fall_evt (fall_evt)
    );

    cfg_ldr_shifter #(.MIRROR(MIRROR)) u_shifter (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (sh_clear),
        .load  (sh_load),
        .shift (sh_shift),
        .din   (r_q.hold),
        .ser   (ser_out)
    );

    always_comb begin
        r_d      = r_q;
        r_d.prog = program_n;
        sh_clear = 1'b0;
        sh_load  = 1'b0;
        sh_shift = 1'b0;
        if (abort || start_evt) begin
            r_d.state     = abort ? LDR_IDLE : LDR_RUN;
            r_d.addr      = '0;
            r_d.bidx      = '0;
            r_d.slot      = '0;
            r_d.bclk_byte = 1'b0;
            r_d.done      = 1'b0;
            sh_clear      = 1'b1;
        end else if (r_q.state == LDR_RUN && fall_evt) begin
            if (r_q.bidx == LAST_BIT) begin
                r_d.bidx = '0;
                if (r_q.slot == SLOT_W'(BYTE_COUNT)) begin
                    r_d.state = LDR_DONE;
                    r_d.done  = 1'b1;
                    sh_clear  = 1'b1;
                end else begin
                    r_d.slot = r_q.slot + SLOT_W'(1);
                    sh_load  = 1'b1;
                end
            end else begin
                r_d.bidx = r_q.bidx + 3'd1;
                sh_shift = (r_q.slot != '0);
            end
            r_d.bclk_byte = (r_d.state == LDR_RUN) && (r_d.bidx >= HIGH_BIT)
                            && (r_d.slot < SLOT_W'(BYTE_COUNT));
            if (!r_q.bclk_byte && r_d.bclk_byte) begin
                r_d.hold = rom_data;
                r_d.addr = r_q.addr + ADDR_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.state <= LDR_IDLE;
            r_q.prog  <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign rom_addr = r_q.addr;
    assign byte_clk = r_q.bclk_byte;
    assign busy     = (r_q.state == LDR_RUN);
    assign done     = r_q.done;

    // R2: the byte read clock rises only together with a falling bit clock
    assert_byteclk_on_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(byte_clk) |-> $fell(bit_clk));

    // R1: each byte capture advances the address by exactly one
    assert_addr_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(byte_clk) |-> rom_addr == $past(rom_addr) + ADDR_W'(1));

    // R4: within a load, serial data moves only with a falling bit clock
    assert_ser_on_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && !$stable(ser_out)) |-> ($fell(bit_clk) || $past(start_evt)));

    // R6: done rises with the full image counted out and the bit clock low
    assert_done_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> (rom_addr == ADDR_W'(BYTE_COUNT)) && !bit_clk && !busy);

    // R7: a wrong mode code leaves every output quiet
    assert_mode_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != MODE_BYTE_LOAD) |=> !busy && !done && !bit_clk && !byte_clk && !ser_out);

    // R8: program_n low clears the address and the done flag
    assert_program_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !program_n |=> (rom_addr == '0) && !done);

endmodule

// File: tb/cfg_byte_loader_tb.sv
`timescale 1ns/1ps
module cfg_byte_loader_tb_top;
    localparam int CD = 2;
    localparam int NB = 16;
    localparam int END_M = 2 * CD * 8 * (NB + 1);

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        program_n = 1'b1;
    logic [2:0]  mode = 3'b100;
    logic        start = 1'b0;
    logic [17:0] rom_addr, rom_addr_m;
    logic [7:0]  rom_data, rom_data_m;
    logic        bit_clk, byte_clk, ser_out, busy, done;
    logic        bit_clk_m, byte_clk_m, ser_out_m, busy_m, done_m;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    function automatic logic [7:0] rom_fn(input logic [17:0] a);
        logic [7:0] lo;
        lo = a[7:0];
        return (lo * 8'd29 + 8'd113) ^ {2'b00, lo[7:2]};
    endfunction

    assign rom_data   = rom_fn(rom_addr);
    assign rom_data_m = rom_fn(rom_addr_m);

    cfg_byte_loader #(.CLK_DIV(CD), .BYTE_COUNT(NB), .MIRROR(1'b0)) dut_i (
        .clk(clk), .rst_n(rst_n), .program_n(program_n), .mode(mode), .start(start),
        .rom_data(rom_data), .rom_addr(rom_addr), .bit_clk(bit_clk), .byte_clk(byte_clk),
        .ser_out(ser_out), .busy(busy), .done(done));

    cfg_byte_loader #(.CLK_DIV(CD), .BYTE_COUNT(NB), .MIRROR(1'b1)) dut_m_i (
        .clk(clk), .rst_n(rst_n), .program_n(program_n), .mode(mode), .start(start),
        .rom_data(rom_data_m), .rom_addr(rom_addr_m), .bit_clk(bit_clk_m), .byte_clk(byte_clk_m),
        .ser_out(ser_out_m), .busy(busy_m), .done(done_m));

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // behavioural reference state, advanced on every rising clock edge
    bit m_active = 0, m_done = 0, m_prog_prev = 1;
    int m_cnt = 0, m_idle_addr = 0;

    always @(posedge clk) begin
        bit st, ab;
        if (!rst_n) begin
            m_active = 0; m_done = 0; m_prog_prev = 1; m_cnt = 0; m_idle_addr = 0;
        end else begin
            st = (start || (program_n && !m_prog_prev)) && mode == 3'b100;
            ab = !program_n || mode != 3'b100;
            m_prog_prev = program_n;
            if (ab) begin
                m_active = 0; m_done = 0; m_idle_addr = 0;
            end else if (st) begin
                m_active = 1; m_done = 0; m_cnt = 0;
            end else if (m_active) begin
                m_cnt++;
                if (m_cnt >= END_M) begin
                    m_active = 0; m_done = 1; m_idle_addr = NB;
                end
            end
        end
    end

    // compare against the reference between clock edges
    always @(negedge clk) begin
        int h, p, slot, idx, e_bit, e_byte, e_addr, e_ser, e_serm;
        if (rst_n) begin
            if (m_active) begin
                h = m_cnt / CD; p = h / 2; slot = p / 8; idx = p % 8;
                e_bit  = h % 2;
                e_byte = (idx >= 4 && slot < NB) ? 1 : 0;
                e_addr = slot + e_byte;
                e_ser  = (slot >= 1) ? int'(rom_fn(18'(slot - 1)) >> idx) & 1 : 0;
                e_serm = (slot >= 1) ? int'(rom_fn(18'(slot - 1)) >> (7 - idx)) & 1 : 0;
            end else begin
                e_bit = 0; e_byte = 0; e_addr = m_idle_addr; e_ser = 0; e_serm = 0;
            end
            chk(int'(rom_addr) == e_addr, "R1 address", int'(rom_addr), e_addr);
            chk(int'(byte_clk) == e_byte, "R2 byte clock", int'(byte_clk), e_byte);
            chk(int'(bit_clk) == e_bit, "R3 bit clock", int'(bit_clk), e_bit);
            chk(int'(ser_out) == e_ser, "R4 serial lsb first", int'(ser_out), e_ser);
            chk(int'(ser_out_m) == e_serm, "R5 mirrored serial", int'(ser_out_m), e_serm);
            chk(int'(done) == int'(m_done), "R6 done", int'(done), int'(m_done));
            chk(int'(busy) == int'(m_active), "R6 busy", int'(busy), int'(m_active));
        end
    end

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_start();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    task automatic report();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        cycles(3);
        // R9: reset state
        chk(rom_addr == 0 && !done && !busy && !bit_clk && !byte_clk && !ser_out,
            "R9 reset state", int'(rom_addr), 0);
        rst_n = 1'b1;
        cycles(10);
        pulse_start();
        cycles(END_M + 20);
        chk(done == 1'b1, "R6 done after full load", int'(done), 1);
        chk(rom_addr == 18'(NB), "R1 final address", int'(rom_addr), NB);

        pulse_start();
        cycles(300);
        program_n = 1'b0;
        cycles(12);
        chk(rom_addr == 0 && !busy, "R8 abort clears address", int'(rom_addr), 0);
        program_n = 1'b1;
        cycles(3);
        chk(busy == 1'b1, "R8 release restarts load", int'(busy), 1);
        cycles(END_M + 20);
        chk(done == 1'b1, "R8 restarted load completes", int'(done), 1);

        mode = 3'b000;
        cycles(2);
        pulse_start();
        cycles(40);
        chk(!busy && !done && !bit_clk, "R7 wrong mode ignores start", int'(busy), 0);
        mode = 3'b100;
        cycles(5);
        pulse_start();
        cycles(200);
        mode = 3'b101;
        cycles(4);
        chk(!busy && rom_addr == 0, "R7 mode change aborts", int'(busy), 0);
        mode = 3'b100;
        cycles(10);
        chk(!busy, "R7 idle after mode restored", int'(busy), 0);
        pulse_start();
        cycles(END_M + 20);
        chk(done == 1'b1 && rom_addr == 18'(NB), "R6 final load done", int'(done), 1);
        report();
    end

    initial begin
        #(4 * 100000);
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        report();
    end

endmodule